// File: doc/BRIEF.md
# DSSS Transmit Port Sequencer

This block sits between a media access controller and the spreading stage of a direct-sequence packet transmitter. The controller opens a burst by raising a transmit-enable input. From then on the block produces a serial bit stream and a one-cycle strobe for each bit, and hands both to the spreader. It also produces a bit clock for the controller. That clock comes from the master clock through a power-of-two divider, and the block samples the controller's serial data on one edge of it. A configuration bit picks which edge.

There are two operating modes, chosen when the burst opens. In external mode the controller supplies every bit, including its own preamble and header, and the bit clock starts at once. In internal mode the block first emits a run of ones, then a 16-bit start-frame delimiter, then a header word taken from a configuration input. The bit clock stays quiet during all of this. When the last header bit has gone out, a ready output goes high and the bit clock starts, so the controller can stream its payload. Dropping transmit-enable ends the burst on the next master-clock edge. Any partly sent byte is discarded.

Top module: `dsss_tx_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `tx_clk`, `tx_rdy` and `bit_vld` all low.
- R2: A burst starts only at a clock edge where `tx_en` is sampled high after it was sampled low at the edge before. A continuously high `tx_en` never opens a second burst.
- R3: A bit period lasts 2·D master cycles, where D = 1, 2, 4 or 8 for `cfg_rate` = 0, 1, 2 or 3. Periods start in the first cycle of the burst. While `tx_clk` runs, it is high for the first D cycles of each period and low for the last D cycles.
- R4: With `cfg_rise_edge` = 0, `tx_din` is sampled at the edge where `tx_clk` goes low. The sampled value appears on `bit_out`, with `bit_vld` high for one cycle, in the first low cycle of `tx_clk`.
- R5: With `cfg_rise_edge` = 1, `tx_din` is sampled at the edge that ends a period, which is where `tx_clk` goes high again. The strobe shows in the first cycle of the next period. The rising edge that opens the clock does not capture.
- R6: In external mode (`cfg_int_pre` = 0), `tx_clk` runs from the first cycle of the burst and `tx_rdy` stays low.
- R7: In internal mode (`cfg_int_pre` = 1), the block emits one bit per period, strobed in the cycle where the period reaches its midpoint D. The bits are PRE_LEN ones, then the delimiter 16'hF3A0 least significant bit first, then `cfg_hdr` least significant bit first. `tx_clk` stays low throughout.
- R8: In internal mode, `tx_rdy` and `tx_clk` both go high in the first cycle after the last header period. `tx_rdy` then stays high until the burst ends, and payload capture follows R4/R5.
- R9: A clock edge that samples `tx_en` low leaves the next cycle idle: `tx_clk`, `tx_rdy` and `bit_vld` low. No partial bits are completed. The next burst starts again from the first preamble bit or the first period.
- R10: `cfg_rate`, `cfg_int_pre`, `cfg_rise_edge` and `cfg_hdr` are latched at the start of a burst. Changing them during the burst does not change the burst's timing, mode or bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable envelope from the controller |
| tx_din | input | 1 | Serial transmit data from the controller, LSB first |
| cfg_int_pre | input | 1 | 1 = generate preamble and header internally |
| cfg_rise_edge | input | 1 | 1 = sample `tx_din` on the rising edge of `tx_clk` |
| cfg_rate | input | 2 | Half-period select: D = 1 << `cfg_rate` master cycles |
| cfg_hdr | input | HDR_W | Header word sent in internal mode |
| tx_clk | output | 1 | Bit clock to the controller |
| tx_rdy | output | 1 | Payload wanted (internal mode only) |
| bit_out | output | 1 | Serial bit to the spreader |
| bit_vld | output | 1 | One-cycle strobe qualifying `bit_out` |

## Verification
A wrong phase count or a wrong latched rate shows up within one bit period. It appears as a `tx_clk` level or a strobe position that is off by a cycle, so the bench compares every output on every cycle against a model driven by elapsed time. A wrong segment counter in internal mode surfaces later. It can show only at the boundaries between the preamble, the delimiter and the header, as a wrong bit value or as `tx_rdy` rising one period early or late. The full internal sequence is therefore run at the slowest and the fastest rates. Stale state after an abort would show only in the following burst, so aborts are followed directly by fresh bursts.

// File: rtl/dsss_tx_pkg.sv
package dsss_tx_pkg;

    localparam int RATE_W   = 2;
    localparam int MAX_RATE = (1 << RATE_W) - 1;
    localparam int PH_W     = MAX_RATE + 1;
    localparam int SFD_LEN  = 16;
    localparam logic [SFD_LEN-1:0] SFD_WORD = 16'hF3A0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_HDR,
        ST_DATA
    } seq_state_e;

    typedef struct packed {
        logic              int_pre;
        logic              rise_edge;
        logic [RATE_W-1:0] rate;
    } tx_mode_t;

    function automatic logic [PH_W-1:0] half_len(input logic [RATE_W-1:0] r);
        return PH_W'(1) << r;
    endfunction

    function automatic logic [PH_W-1:0] last_phase(input logic [RATE_W-1:0] r);
        return half_len(r) + half_len(r) - PH_W'(1);
    endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer
    import dsss_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              at_mid_m1,
    output logic              at_last,
    output logic              clk_hi
);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] half;
    logic [PH_W-1:0] last;

    always_comb begin
        half      = half_len(rate);
        last      = last_phase(rate);
        at_mid_m1 = (ph_q == half - PH_W'(1));
        at_last   = (ph_q == last);
        clk_hi    = (ph_q < half);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_q <= '0;
        end else if (at_last) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + PH_W'(1);
        end
    end

endmodule

// File: rtl/tx_frame_gen.sv
module tx_frame_gen
    import dsss_tx_pkg::*;
#(
    parameter int PRE_LEN = 128,
    parameter int HDR_W   = 32,
    parameter int CNT_W   = 7
) (
    input  seq_state_e        state,
    input  logic [CNT_W-1:0]  idx,
    input  logic [HDR_W-1:0]  hdr,
    output logic              gen_bit,
    output logic              seg_last,
    output seq_state_e        seg_next
);

    logic [HDR_W-1:0]   hdr_sh;
    logic [SFD_LEN-1:0] sfd_sh;

    always_comb begin
        hdr_sh   = hdr >> idx;
        sfd_sh   = SFD_WORD >> idx;
        gen_bit  = 1'b0;
        seg_last = 1'b0;
        seg_next = ST_IDLE;
        unique case (state)
            ST_PRE: begin
                gen_bit  = 1'b1;
                seg_last = (idx == CNT_W'(PRE_LEN - 1));
                seg_next = ST_SFD;
            end
            ST_SFD: begin
                gen_bit  = sfd_sh[0];
                seg_last = (idx == CNT_W'(SFD_LEN - 1));
                seg_next = ST_HDR;
            end
            ST_HDR: begin
                gen_bit  = hdr_sh[0];
                seg_last = (idx == CNT_W'(HDR_W - 1));
                seg_next = ST_DATA;
            end
            default: begin
                gen_bit  = 1'b0;
                seg_last = 1'b0;
                seg_next = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/dsss_tx_seq.sv
module dsss_tx_seq
    import dsss_tx_pkg::*;
#(
    parameter int PRE_LEN = 128,
    parameter int HDR_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              tx_din,
    input  logic              cfg_int_pre,
    input  logic              cfg_rise_edge,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [HDR_W-1:0]  cfg_hdr,
    output logic              tx_clk,
    output logic              tx_rdy,
    output logic              bit_out,
    output logic              bit_vld
);

    localparam int SEG_A   = (PRE_LEN > HDR_W) ? PRE_LEN : HDR_W;
    localparam int SEG_MAX = (SEG_A > SFD_LEN) ? SEG_A : SFD_LEN;
    localparam int CNT_W   = $clog2(SEG_MAX);

    seq_state_e       state_q;
    seq_state_e       seg_next;
    tx_mode_t         mode_q;
    logic [HDR_W-1:0] hdr_q;
    logic [CNT_W-1:0] idx_q;
    logic             en_q;
    logic             at_mid_m1;
    logic             at_last;
    logic             clk_hi;
    logic             gen_bit;
    logic             seg_last;
    logic             data_take;
    logic             active;

    assign active = (state_q != ST_IDLE);

    tx_bit_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (active),
        .rate      (mode_q.rate),
        .at_mid_m1 (at_mid_m1),
        .at_last   (at_last),
        .clk_hi    (clk_hi)
    );

    tx_frame_gen #(
        .PRE_LEN (PRE_LEN),
        .HDR_W   (HDR_W),
        .CNT_W   (CNT_W)
    ) u_gen (
        .state    (state_q),
        .idx      (idx_q),
        .hdr      (hdr_q),
        .gen_bit  (gen_bit),
        .seg_last (seg_last),
        .seg_next (seg_next)
    );

    assign data_take = mode_q.rise_edge ? at_last : at_mid_m1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            hdr_q   <= '0;
            idx_q   <= '0;
            en_q    <= 1'b0;
            bit_out <= 1'b0;
            bit_vld <= 1'b0;
        end else begin
            en_q    <= tx_en;
            bit_vld <= 1'b0;
            if (!tx_en) begin
                state_q <= ST_IDLE;
                idx_q   <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (!en_q) begin
                            mode_q.int_pre   <= cfg_int_pre;
                            mode_q.rise_edge <= cfg_rise_edge;
                            mode_q.rate      <= cfg_rate;
                            hdr_q            <= cfg_hdr;
                            idx_q            <= '0;
                            state_q          <= cfg_int_pre ? ST_PRE : ST_DATA;
                        end
                    end
                    ST_PRE, ST_SFD, ST_HDR: begin
                        if (at_mid_m1) begin
                            bit_vld <= 1'b1;
                            bit_out <= gen_bit;
                        end
                        if (at_last) begin
                            if (seg_last) begin
                                idx_q   <= '0;
                                state_q <= seg_next;
                            end else begin
                                idx_q <= idx_q + CNT_W'(1);
                            end
                        end
                    end
                    ST_DATA: begin
                        if (data_take) begin
                            bit_vld <= 1'b1;
                            bit_out <= tx_din;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign tx_clk = (state_q == ST_DATA) && clk_hi;
    assign tx_rdy = (state_q == ST_DATA) && mode_q.int_pre;

endmodule

// File: rtl/dsss_tx_seq_chk.sv
module dsss_tx_seq_chk
    import dsss_tx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tx_en,
    input logic       tx_clk,
    input logic       tx_rdy,
    input logic       bit_vld,
    input seq_state_e state_q,
    input tx_mode_t   mode_q
);

    logic rst_d;

    always @(posedge clk) begin
        if (rst_d) begin
            AST_RST_QUIET: assert (!tx_clk && !tx_rdy && !bit_vld); // R1
        end
        rst_d <= rst;
    end

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (!tx_clk && !tx_rdy && !bit_vld)); // R9

    AST_RDY_OPENS_CLK: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_rdy) |-> tx_clk); // R8

    AST_GEN_CLK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PRE || state_q == ST_SFD || state_q == ST_HDR) |-> !tx_clk); // R7

    AST_RDY_INT_ONLY: assert property (@(posedge clk) disable iff (rst)
        tx_rdy |-> mode_q.int_pre); // R6

    AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (rst)
        bit_vld |=> !bit_vld); // R3

    AST_FALL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && state_q == ST_DATA && !mode_q.rise_edge) |-> !tx_clk); // R4

    AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && state_q == ST_DATA && mode_q.rise_edge) |-> tx_clk); // R5

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(mode_q)); // R10

endmodule

bind dsss_tx_seq dsss_tx_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tx_en   (tx_en),
    .tx_clk  (tx_clk),
    .tx_rdy  (tx_rdy),
    .bit_vld (bit_vld),
    .state_q (state_q),
    .mode_q  (mode_q)
);

// File: tb/dsss_tx_seq_tb_top.sv
module dsss_tx_seq_tb_top;

    localparam int PRE_LEN = 128;
    localparam int HDR_W   = 32;
    localparam int SFD_LEN = 16;
    localparam logic [15:0] SFD_REF = 16'hF3A0;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tx_en = 1'b0;
    logic             tx_din = 1'b0;
    logic             cfg_int_pre = 1'b0;
    logic             cfg_rise_edge = 1'b0;
    logic [1:0]       cfg_rate = 2'd0;
    logic [HDR_W-1:0] cfg_hdr = 32'h5A3C_96E1;
    logic             tx_clk;
    logic             tx_rdy;
    logic             bit_out;
    logic             bit_vld;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state: elapsed cycles since burst start (-1 = idle)
    int               k = -1;
    bit               m_int, m_rise, en_prev;
    int               m_p, m_h;
    logic [HDR_W-1:0] m_hdr;
    bit               e_vld;
    logic             e_bit;
    int               seed = 7;

    always #5 clk = ~clk;

    dsss_tx_seq #(.PRE_LEN(PRE_LEN), .HDR_W(HDR_W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .tx_en         (tx_en),
        .tx_din        (tx_din),
        .cfg_int_pre   (cfg_int_pre),
        .cfg_rise_edge (cfg_rise_edge),
        .cfg_rate      (cfg_rate),
        .cfg_hdr       (cfg_hdr),
        .tx_clk        (tx_clk),
        .tx_rdy        (tx_rdy),
        .bit_out       (bit_out),
        .bit_vld       (bit_vld)
    );

    function automatic logic gen_ref(input int i);
        if (i < PRE_LEN) return 1'b1;
        if (i < PRE_LEN + SFD_LEN) return SFD_REF[i - PRE_LEN];
        return m_hdr[i - PRE_LEN - SFD_LEN];
    endfunction

    task automatic check(input string tag, input string sig, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, sig, act, exp, $time);
        end
    endtask

    // advance model over one clock edge with the inputs the edge sees
    task automatic model_edge(input logic en, input logic din);
        int g;
        e_vld = 1'b0;
        if (rst) begin
            k = -1;
            en_prev = 1'b0;
        end else begin
            if (!en) begin
                k = -1;
            end else if (k < 0) begin
                if (!en_prev) begin
                    m_int  = cfg_int_pre;
                    m_rise = cfg_rise_edge;
                    m_h    = 1 << cfg_rate;
                    m_p    = 2 * m_h;
                    m_hdr  = cfg_hdr;
                    k      = 0;
                end
            end else begin
                g = (PRE_LEN + SFD_LEN + HDR_W) * m_p;
                if (m_int && k < g) begin
                    if (k % m_p == m_h - 1) begin
                        e_vld = 1'b1;
                        e_bit = gen_ref(k / m_p);
                    end
                end else if (m_rise ? (k % m_p == m_p - 1) : (k % m_p == m_h - 1)) begin
                    e_vld = 1'b1;
                    e_bit = din;
                end
                k++;
            end
            en_prev = en;
        end
    endtask

    task automatic step(input logic en, input string tag);
        int g;
        bit running, e_clk, e_rdy;
        seed   = seed * 1103515245 + 12345;
        tx_en  = en;
        tx_din = seed[16];
        model_edge(en, tx_din);
        @(negedge clk);
        g       = (PRE_LEN + SFD_LEN + HDR_W) * m_p;
        running = (k >= 0) && (!m_int || k >= g);
        e_clk   = running && ((k % m_p) < m_h);
        e_rdy   = running && m_int;
        check(tag, "tx_clk", tx_clk, e_clk);
        check(tag, "tx_rdy", tx_rdy, e_rdy);
        check(tag, "bit_vld", bit_vld, e_vld);
        if (e_vld) check(tag, "bit_out", bit_out, e_bit);
    endtask

    task automatic run(input int n, input logic en, input string tag);
        for (int i = 0; i < n; i++) step(en, tag);
    endtask

    initial begin
        // R1: reset quiet
        rst = 1'b1;
        run(4, 1'b0, "R1");
        rst = 1'b0;
        run(3, 1'b0, "R1");

        // external mode, falling capture, fastest rate (R2 start, R3, R4, R6)
        cfg_int_pre = 1'b0; cfg_rise_edge = 1'b0; cfg_rate = 2'd0;
        run(50, 1'b1, "R2 R3 R4 R6");
        run(3, 1'b0, "R9");

        // external mode, rising capture, rate 2 (R3 R5 R6)
        cfg_rise_edge = 1'b1; cfg_rate = 2'd2;
        run(90, 1'b1, "R3 R5 R6");
        run(2, 1'b0, "R9");

        // configuration changed during burst is ignored (R10)
        cfg_rise_edge = 1'b0; cfg_rate = 2'd1;
        run(10, 1'b1, "R10");
        cfg_rate = 2'd3; cfg_rise_edge = 1'b1; cfg_int_pre = 1'b1; cfg_hdr = 32'h0000_FFFF;
        run(60, 1'b1, "R10");
        run(2, 1'b0, "R9");

        // internal preamble, falling capture, rate 0 (R7 R8 R4)
        cfg_int_pre = 1'b1; cfg_rise_edge = 1'b0; cfg_rate = 2'd0; cfg_hdr = 32'hC3A5_1E78;
        run(352 + 60, 1'b1, "R7 R8 R4");
        run(2, 1'b0, "R9");

        // internal preamble, rising capture, slowest rate (R7 R8 R5 R3)
        cfg_rise_edge = 1'b1; cfg_rate = 2'd3; cfg_hdr = 32'h8000_0001;
        run(2816 + 120, 1'b1, "R7 R8 R5 R3");
        run(2, 1'b0, "R9");

        // abort mid-header then restart from preamble (R9 R2)
        cfg_rise_edge = 1'b0; cfg_rate = 2'd1; cfg_hdr = 32'h1234_5678;
        run(610, 1'b1, "R9 R7");
        run(1, 1'b0, "R9");
        cfg_hdr = 32'hFEDC_BA98;
        run(704 + 40, 1'b1, "R9 R2 R8");

        // abort mid-byte in external mode, immediate restart (R9)
        run(1, 1'b0, "R9");
        cfg_int_pre = 1'b0; cfg_rate = 2'd2;
        run(37, 1'b1, "R9 R6");
        run(1, 1'b0, "R9");
        run(40, 1'b1, "R9 R2 R4");
        run(3, 1'b0, "R9");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule